// File: doc/BRIEF.md
# Paired PWM Clock Prescaler

This block generates two pulse-width-modulated waveforms that share a single clock front end. A shared source selector picks either the high-frequency oscillator strobe or the bus clock strobe, and a shared power-of-two divider slows the selected strobe down. Each channel then has its own linear prescaler, a period counter and a duty comparator. The shared source and divider set the time step of period and duty for both channels, so the two channels always tick on the same divided clock.

Source clocks are single-cycle enable strobes in the one system clock domain. The shared configuration is written with a one-cycle write strobe that names the channel doing the write. Once any channel is enabled the shared setting is locked: a write is accepted only when no channel is enabled, or when the writing channel is the only one enabled. A refused write leaves the setting unchanged and raises a sticky conflict flag. All configuration arrives as plain level ports, and no data stream passes through the block, so no port has back-pressure. A write strobe is always taken in the cycle it is high, and the block never stalls it.

Top module: `pwm_pair_prescaler`

## Requirements
- R1: After reset both outputs are low, `shr_locked` and `conflict` are low, the source is the oscillator and the divider exponent is 0. With these defaults, k=0, period 2 and duty 1, the output alternates one cycle high and one cycle low when the oscillator strobe is high every cycle.
- R2: `shr_src` = 0 selects `osc_stb` and `shr_src` = 1 selects `bus_stb` as the source strobe of both channels.
- R3: The divider emits one tick every 2^M selected strobes. M=0 passes every strobe through, and a written M above 8 is stored as 8.
- R4: Channel c advances its count once every `ch_pre[c]`+1 divider ticks, so one count step lasts (k+1)·2^M source strobes.
- R5: The count runs from 0 to PERIOD-1 and wraps, and the output is high while the count is below DUTY. DUTY=0 gives a constant low, DUTY>=PERIOD gives a constant high, and PERIOD=0 acts as PERIOD=1.
- R6: A new period or duty takes effect only when the period counter wraps. The period in progress finishes with the old values.
- R7: A disabled channel drives a low output starting the cycle after its enable falls. Enabling a channel restarts its prescaler and count from zero. While no channel is enabled the divider is held at phase zero, so the first step after an enable is a full step.
- R8: `shr_locked` is high from the cycle after any enable is set. A shared write is accepted when no channel is enabled, or when only the channel named by `shr_wr_ch` is enabled, and an accepted write restarts the divider phase. Any other write is refused and leaves source and M unchanged.
- R9: A refused write sets `conflict` on the next cycle. `conflict` stays high until a cycle with `conflict_clr` high and no refused write, and a refused write in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_stb | input | 1 | Oscillator source strobe |
| bus_stb | input | 1 | Bus clock source strobe |
| shr_wr | input | 1 | Shared configuration write strobe |
| shr_wr_ch | input | 1 | Index of the channel issuing the shared write |
| shr_src | input | 1 | Source select value (0 oscillator, 1 bus) |
| shr_div | input | 4 | Divider exponent M |
| ch_en | input | 2 | Per-channel enable |
| ch_pre | input | 2x8 | Per-channel prescale k |
| ch_period | input | 2x16 | Per-channel period in steps |
| ch_duty | input | 2x16 | Per-channel high time in steps |
| conflict_clr | input | 1 | Clears the conflict flag |
| pwm | output | 2 | PWM waveforms |
| shr_locked | output | 1 | Shared setting is locked |
| conflict | output | 1 | Sticky flag for a refused shared write |

## Verification
A wrong divider phase or prescaler count shows up as a high or low run of the wrong length. That error appears within one count step, at most 256·256 strobes, and it repeats in every period after that. A lock decision that goes the wrong way shows at `conflict` one cycle after the write, and it also changes the run lengths of the running channel. A period or duty register loaded at the wrong moment gives a single period of mixed length. For that reason the runs are compared one by one, in order, across the moment a value changes.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int unsigned PAIR_N  = 2;
  localparam int unsigned MAX_EXP = 8;
  localparam int unsigned EXP_W   = 4;

  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_BUS = 1'b1
  } src_e;

  typedef struct packed {
    src_e             src;
    logic [EXP_W-1:0] exp;
  } shr_cfg_t;
endpackage

// File: rtl/pwm_shared_cfg.sv
module pwm_shared_cfg
  import pwm_pair_pkg::*;
#(
  parameter int unsigned CH_N = PAIR_N
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CH_N-1:0]         en_q,
  input  logic                    wr,
  input  logic [$clog2(CH_N)-1:0] wr_ch,
  input  logic                    src_in,
  input  logic [EXP_W-1:0]        exp_in,
  input  logic                    clr,
  output shr_cfg_t                cfg_q,
  output logic                    accept,
  output logic                    conflict_q
);
  logic [CH_N-1:0]  writer_bit;
  logic [EXP_W-1:0] exp_sat;
  logic             refused;

  assign writer_bit = CH_N'(1) << wr_ch;
  // only an idle pair or a lone writer may change the shared clock
  assign accept  = wr && ((en_q == '0) || (en_q == writer_bit));
  assign refused = wr && !accept;
  assign exp_sat = (exp_in > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '{src: SRC_OSC, exp: '0};
      conflict_q <= 1'b0;
    end else begin
      if (accept) begin
        cfg_q <= '{src: src_e'(src_in), exp: exp_sat};
      end
      if (refused) begin
        conflict_q <= 1'b1;
      end else if (clr) begin
        conflict_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_pow2_div.sv
module pwm_pow2_div
  import pwm_pair_pkg::*;
#(
  parameter int unsigned CNT_W = MAX_EXP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             stb,
  input  logic [EXP_W-1:0] exp,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   span_m1;
  logic [CNT_W-1:0] mask;

  assign span    = (CNT_W+1)'(1) << exp;
  assign span_m1 = span - 1'b1;
  assign mask    = span_m1[CNT_W-1:0];
  // the low M bits all ones marks the last strobe of a group of 2^M
  assign tick    = stb && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (stb) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm
);
  logic [PRE_W-1:0] pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] duty_q;
  logic             step;
  logic             at_wrap;

  assign step    = tick && (pc_q >= pre);
  assign at_wrap = (per_q <= CNT_W'(1)) || (cnt_q >= (per_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || !en_q) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      per_q  <= period;
      duty_q <= duty;
    end else begin
      if (tick) begin
        pc_q <= step ? '0 : pc_q + 1'b1;
      end
      if (step) begin
        if (at_wrap) begin
          cnt_q  <= '0;
          per_q  <= period;
          duty_q <= duty;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pwm = en_q && (cnt_q < duty_q);
endmodule

// File: rtl/pwm_pair_prescaler.sv
module pwm_pair_prescaler
  import pwm_pair_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         osc_stb,
  input  logic                         bus_stb,
  input  logic                         shr_wr,
  input  logic [$clog2(PAIR_N)-1:0]    shr_wr_ch,
  input  logic                         shr_src,
  input  logic [EXP_W-1:0]             shr_div,
  input  logic [PAIR_N-1:0]            ch_en,
  input  logic [PAIR_N-1:0][PRE_W-1:0] ch_pre,
  input  logic [PAIR_N-1:0][CNT_W-1:0] ch_period,
  input  logic [PAIR_N-1:0][CNT_W-1:0] ch_duty,
  input  logic                         conflict_clr,
  output logic [PAIR_N-1:0]            pwm,
  output logic                         shr_locked,
  output logic                         conflict
);
  localparam int unsigned CH_N = PAIR_N;

  logic [CH_N-1:0] en_q;
  shr_cfg_t        cfg;
  logic            accept;
  logic            src_stb;
  logic            div_restart;
  logic            div_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      en_q <= ch_en;
    end
  end

  pwm_shared_cfg #(.CH_N(CH_N)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .en_q       (en_q),
    .wr         (shr_wr),
    .wr_ch      (shr_wr_ch),
    .src_in     (shr_src),
    .exp_in     (shr_div),
    .clr        (conflict_clr),
    .cfg_q      (cfg),
    .accept     (accept),
    .conflict_q (conflict)
  );

  assign src_stb     = (cfg.src == SRC_BUS) ? bus_stb : osc_stb;
  assign div_restart = (en_q == '0) || accept;

  pwm_pow2_div #(.CNT_W(MAX_EXP)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (div_restart),
    .stb     (src_stb),
    .exp     (cfg.exp),
    .tick    (div_tick)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .en_q   (en_q[c]),
      .tick   (div_tick),
      .pre    (ch_pre[c]),
      .period (ch_period[c]),
      .duty   (ch_duty[c]),
      .pwm    (pwm[c])
    );
  end

  assign shr_locked = |en_q;
endmodule

// File: rtl/pwm_pair_checker.sv
module pwm_pair_checker
  import pwm_pair_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [PAIR_N-1:0] ch_en,
  input logic              shr_wr,
  input logic              conflict_clr,
  input logic              conflict,
  input logic              shr_locked,
  input logic [PAIR_N-1:0] pwm,
  input logic [PAIR_N-1:0] en_q,
  input shr_cfg_t          cfg
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pwm == '0 && !conflict && !shr_locked));

  assert_exp_saturated_R3: assert property (@(posedge clk) disable iff (rst)
    cfg.exp <= EXP_W'(MAX_EXP));

  assert_ch0_off_low_R7: assert property (@(posedge clk) disable iff (rst)
    !ch_en[0] |=> !pwm[0]);

  assert_ch1_off_low_R7: assert property (@(posedge clk) disable iff (rst)
    !ch_en[1] |=> !pwm[1]);

  assert_locked_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_en != '0) |=> shr_locked);

  assert_both_on_refuse_R8: assert property (@(posedge clk) disable iff (rst)
    (shr_wr && en_q == '1) |=> (conflict && $stable(cfg)));

  assert_idle_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (shr_wr && en_q == '0 && !conflict_clr) |=> $stable(conflict));

  assert_conflict_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (conflict && !conflict_clr) |=> conflict);

  assert_conflict_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (conflict_clr && !shr_wr) |=> !conflict);
endmodule

bind pwm_pair_prescaler pwm_pair_checker i_chk (
  .clk          (clk),
  .rst          (rst),
  .ch_en        (ch_en),
  .shr_wr       (shr_wr),
  .conflict_clr (conflict_clr),
  .conflict     (conflict),
  .shr_locked   (shr_locked),
  .pwm          (pwm),
  .en_q         (en_q),
  .cfg          (cfg)
);

// File: tb/test_pwm_pair_prescaler.sv
`timescale 1ns/1ps
module test_pwm_pair_prescaler;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             osc_stb = 1'b1;
  logic             bus_stb = 1'b0;
  logic             shr_wr = 1'b0;
  logic [0:0]       shr_wr_ch = 1'b0;
  logic             shr_src = 1'b0;
  logic [3:0]       shr_div = 4'd0;
  logic [1:0]       ch_en = 2'b00;
  logic [1:0][7:0]  ch_pre = '0;
  logic [1:0][15:0] ch_period = '0;
  logic [1:0][15:0] ch_duty = '0;
  logic             conflict_clr = 1'b0;
  logic [1:0]       pwm;
  logic             shr_locked;
  logic             conflict;

  always #2.5 clk = ~clk;

  pwm_pair_prescaler i_pwm_pair_prescaler (
    .clk(clk), .rst(rst), .osc_stb(osc_stb), .bus_stb(bus_stb),
    .shr_wr(shr_wr), .shr_wr_ch(shr_wr_ch), .shr_src(shr_src), .shr_div(shr_div),
    .ch_en(ch_en), .ch_pre(ch_pre), .ch_period(ch_period), .ch_duty(ch_duty),
    .conflict_clr(conflict_clr), .pwm(pwm), .shr_locked(shr_locked), .conflict(conflict)
  );

  typedef struct {
    bit    lvl;
    bit    any;
    int    len;
    string req;
  } run_t;

  run_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  int   mon_ch = 0;
  int   mskip = 1;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input bit lvl, input bit any, input int len, input string req);
    run_t r;
    r.lvl = lvl; r.any = any; r.len = len; r.req = req;
    exp_q.push_back(r);
  endtask

  // bus strobe: high every other cycle
  initial begin
    forever begin
      @(negedge clk);
      bus_stb = ~bus_stb;
    end
  end

  // monitor: measures run lengths of the watched output and compares them in order
  initial begin
    bit   started;
    bit   prev;
    int   run;
    int   skipped;
    run_t e;
    started = 1'b0; prev = 1'b0; run = 0; skipped = 0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        started = 1'b0;
      end else if (!started) begin
        started = 1'b1; prev = pwm[mon_ch]; run = 1; skipped = 0;
      end else if (pwm[mon_ch] == prev) begin
        run++;
      end else begin
        if (skipped < mskip) begin
          skipped++;
        end else if (exp_q.size() > 0 && !exp_q[0].any && exp_q[0].lvl != prev
                     && skipped == mskip) begin
          skipped++;
        end else if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk((e.any || e.lvl == prev) && e.len == run, e.req, run, e.len);
        end
        prev = pwm[mon_ch];
        run  = 1;
      end
    end
  end

  task automatic drain(input string req);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 8000) begin
      @(posedge clk);
      t++;
    end
    if (exp_q.size() != 0) begin
      chk(1'b0, req, exp_q.size(), 0);
      exp_q.delete();
    end
  endtask

  task automatic shr_write(input bit ch, input bit src, input logic [3:0] m);
    @(negedge clk);
    shr_wr = 1'b1; shr_wr_ch = ch; shr_src = src; shr_div = m;
    @(negedge clk);
    shr_wr = 1'b0;
  endtask

  task automatic stop_all();
    @(negedge clk);
    mon_on = 1'b0;
    ch_en  = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi0;
    int hi1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pwm == 2'b00, "R1 pwm after reset", pwm, 0);
    chk(!shr_locked, "R1 locked after reset", shr_locked, 0);
    chk(!conflict, "R1 conflict after reset", conflict, 0);

    // R1: default oscillator source, M=0
    ch_pre[0] = 8'd0; ch_period[0] = 16'd2; ch_duty[0] = 16'd1;
    mon_ch = 0; mskip = 1; mon_on = 1'b1;
    push(1, 0, 1, "R1 default clock high"); push(0, 0, 1, "R1 default clock low");
    push(1, 0, 1, "R1 default clock high"); push(0, 0, 1, "R1 default clock low");
    @(negedge clk); ch_en = 2'b01;
    drain("R1 runs missing");
    stop_all();

    // R4/R5: M=1, k=2 gives 6-cycle steps; period 4, duty 1
    shr_write(0, 0, 4'd1);
    chk(!conflict, "R8 idle write accepted", conflict, 0);
    ch_pre[0] = 8'd2; ch_period[0] = 16'd4; ch_duty[0] = 16'd1;
    mskip = 1; mon_on = 1'b1;
    push(1, 0, 6, "R4 step length high"); push(0, 0, 18, "R5 low remainder");
    push(1, 0, 6, "R4 step length high"); push(0, 0, 18, "R5 low remainder");
    @(negedge clk); ch_en = 2'b01;
    @(negedge clk);
    chk(shr_locked, "R8 locked after enable", shr_locked, 1);
    drain("R4 runs missing");

    // R6: duty change waits for the wrap
    push(1, 0, 6, "R6 old duty kept"); push(0, 0, 18, "R6 old duty kept");
    push(1, 0, 18, "R6 new duty high"); push(0, 0, 6, "R6 new duty low");
    @(negedge clk); ch_duty[0] = 16'd3;
    drain("R6 runs missing");

    // R8/R9: write from ch1 while only ch0 runs is refused
    shr_write(1, 1, 4'd0);
    chk(conflict, "R9 refused write sets conflict", conflict, 1);
    push(1, 0, 18, "R8 refused write no effect"); push(0, 0, 6, "R8 refused write no effect");
    push(1, 0, 18, "R8 refused write no effect"); push(0, 0, 6, "R8 refused write no effect");
    drain("R8 runs missing");
    @(negedge clk); conflict_clr = 1'b1;
    @(negedge clk); conflict_clr = 1'b0;
    chk(!conflict, "R9 clear drops conflict", conflict, 0);

    // R8: sole enabled writer is accepted, M=0 gives 3-cycle steps
    shr_write(0, 0, 4'd0);
    chk(!conflict, "R8 sole writer accepted", conflict, 0);
    mon_on = 1'b0; @(negedge clk);
    mskip = 2; mon_on = 1'b1;
    push(1, 0, 9, "R8 new divider high"); push(0, 0, 3, "R8 new divider low");
    push(1, 0, 9, "R8 new divider high"); push(0, 0, 3, "R8 new divider low");
    drain("R8 runs missing");

    // R8: both enabled, any write refused
    ch_pre[1] = 8'd0; ch_period[1] = 16'd2; ch_duty[1] = 16'd1;
    @(negedge clk); ch_en = 2'b11;
    @(negedge clk);
    shr_write(0, 1, 4'd5);
    chk(conflict, "R8 both enabled refuses", conflict, 1);
    mon_on = 1'b0; @(negedge clk);
    mskip = 1; mon_on = 1'b1;
    push(1, 0, 9, "R8 both enabled no effect"); push(0, 0, 3, "R8 both enabled no effect");
    drain("R8 runs missing");

    // R9: refusal and clear in the same cycle keeps the flag
    @(negedge clk); conflict_clr = 1'b1;
    @(negedge clk); conflict_clr = 1'b0;
    chk(!conflict, "R9 clear", conflict, 0);
    @(negedge clk); shr_wr = 1'b1; shr_wr_ch = 1'b0; conflict_clr = 1'b1;
    @(negedge clk); shr_wr = 1'b0; conflict_clr = 1'b0;
    chk(conflict, "R9 set wins over clear", conflict, 1);
    @(negedge clk); conflict_clr = 1'b1;
    @(negedge clk); conflict_clr = 1'b0;

    // R7: disable drops the outputs and the lock
    @(negedge clk); mon_on = 1'b0; ch_en = 2'b00;
    @(negedge clk);
    chk(pwm == 2'b00, "R7 disabled output low", pwm, 0);
    chk(!shr_locked, "R8 unlocked when idle", shr_locked, 0);
    repeat (2) @(negedge clk);

    // R2: bus strobe source, every other cycle
    shr_write(0, 1, 4'd0);
    chk(!conflict, "R2 source write accepted", conflict, 0);
    ch_pre[1] = 8'd0; ch_period[1] = 16'd4; ch_duty[1] = 16'd2;
    mon_ch = 1; mskip = 2; mon_on = 1'b1;
    push(0, 0, 4, "R2 bus step low"); push(1, 0, 4, "R2 bus step high");
    push(0, 0, 4, "R2 bus step low"); push(1, 0, 4, "R2 bus step high");
    @(negedge clk); ch_en = 2'b10;
    drain("R2 runs missing");
    stop_all();

    // R3: M=12 saturates at 8
    shr_write(0, 0, 4'd12);
    ch_pre[0] = 8'd0; ch_period[0] = 16'd2; ch_duty[0] = 16'd1;
    mon_ch = 0; mskip = 1; mon_on = 1'b1;
    push(1, 0, 256, "R3 saturated divider high"); push(0, 0, 256, "R3 saturated divider low");
    @(negedge clk); ch_en = 2'b01;
    drain("R3 runs missing");
    stop_all();

    // R5: duty >= period constant high, duty 0 constant low
    shr_write(0, 0, 4'd0);
    ch_pre = '0;
    ch_period[0] = 16'd3; ch_duty[0] = 16'd5;
    ch_period[1] = 16'd3; ch_duty[1] = 16'd0;
    @(negedge clk); ch_en = 2'b11;
    hi0 = 0; hi1 = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hi0 += int'(pwm[0]);
      hi1 += int'(pwm[1]);
    end
    chk(hi0 == 40, "R5 duty above period stays high", hi0, 40);
    chk(hi1 == 0, "R5 zero duty stays low", hi1, 0);
    stop_all();

    // R5: period 0 acts as period 1
    ch_period[0] = 16'd0; ch_duty[0] = 16'd1;
    @(negedge clk); ch_en = 2'b01;
    hi0 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      hi0 += int'(pwm[0]);
    end
    chk(hi0 == 20, "R5 zero period constant high", hi0, 20);
    stop_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule